// File: doc/BRIEF.md
# SPI Burst Word-Access Target

This block is a SPI target (mode 0, MSB first) that lets an external host read and write a 512-word internal memory and a one-word status register using burst transactions. Chip select is low for the whole transaction. The host first shifts in a 32-bit command word that carries an operation, a byte address and a word count. The data words follow back to back with no further command word, and each word goes to the next 32-bit location.

The SPI pins are brought into the system clock domain through synchronizers, and SPI clock edges are detected there. A small state machine decodes the command word, steps the word pointer, commits full write words to memory and prefetches read words. It checks each transaction for framing faults and records any fault in a sticky error flag. The host reads that flag at the status address and clears it by writing 1.

State machine: `ST_IDLE` (chip select high), `ST_HDR` (collecting the command word), `ST_RD` (read burst), `ST_WR` (write burst), `ST_DRAIN` (faulted transaction: bits are counted but nothing is stored and MISO returns zeros).

Transitions:
- `ST_IDLE`→`ST_HDR` when chip select falls.
- `ST_HDR`→`ST_RD` or `ST_HDR`→`ST_WR` when a valid command word completes.
- `ST_HDR`→`ST_DRAIN` when an invalid command word completes.
- `ST_RD`/`ST_WR`→`ST_DRAIN` when a data word completes beyond the count.
- `ST_HDR`/`ST_RD`/`ST_WR`/`ST_DRAIN`→`ST_IDLE` when chip select rises.

Top module: `spi_burst_slave`

## Requirements
- R1: The command word is shifted MSB first and is laid out as follows: operation code in bits [31:24], byte address in bits [23:8], word count in bits [7:0]. Data bits are sampled on rising SCLK.
- R2: Operation code 0x61 writes the given number of words to consecutive 32-bit locations, starting at the command address.
- R3: Operation code 0x41 returns words from consecutive locations. MISO presents the first data word's MSB after the falling SCLK edge that follows the command word's last bit, and each later word follows with no gap. MISO is 0 while chip select is high.
- R4: Memory occupies byte addresses 0x8000 to 0x87FF, which is 512 words, and both of the boundary words are accessible.
- R5: If the number of SCLK bits in a transaction is not a multiple of 32, the error flag is set. A partial final write word is not stored.
- R6: If the number of data words differs from the word count, the error flag is set. Words beyond the count are not stored.
- R7: A word count of 0 sets the error flag.
- R8: An operation code other than 0x41 or 0x61 sets the error flag, and nothing is written in that transaction.
- R9: A burst that would pass beyond 0x87FF, or a command address that is not 4-byte aligned, sets the error flag, and nothing is written in that transaction.
- R10: The status register is at byte address 0x000C and can only be accessed with a word count of 1. Bit 0 holds the error flag, which stays set across transactions. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R11: After reset, MISO is 0 and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The hardest case to reach is a fault in the middle of a burst that must leave memory untouched. Examples are an over-long burst, a truncated last word, and an unaligned or out-of-range command. Each scenario first writes a known pattern with a clean burst, then issues the faulty transaction, and then reads the locations back. It also reads the status word to confirm the flag, and clears the flag before the next scenario. Read timing at the command-to-data boundary is checked by sampling MISO just before every rising SCLK edge, including the first data bit.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam logic [7:0] OP_READ  = 8'h41;
    localparam logic [7:0] OP_WRITE = 8'h61;
    localparam int         ADDR_W   = 16;
    localparam int         PTR_W    = ADDR_W - 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_RD,
        ST_WR,
        ST_DRAIN
    } st_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_word_mem.sv
module spi_word_mem #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
    import spi_burst_pkg::*;
#(
    parameter int MEM_BASE    = 32'h8000,
    parameter int MEM_BYTES   = 2048,
    parameter int STATUS_ADDR = 32'h000C,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int               MEM_WORDS = MEM_BYTES / 4;
    localparam int               MEM_AW    = $clog2(MEM_WORDS);
    localparam logic [PTR_W-1:0] BASE_W    = PTR_W'(MEM_BASE / 4);
    localparam logic [PTR_W-1:0] STAT_W    = PTR_W'(STATUS_ADDR / 4);
    localparam logic [PTR_W:0]   WORDS_P   = (PTR_W+1)'(MEM_WORDS);

    // pin synchronisation and edge detection
    logic sclk_s, csn_s, mosi_s, sclk_d, csn_d;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sclk, spi_cs_n, spi_mosi}),
        .dout ({sclk_s, csn_s, mosi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    logic sclk_rise, sclk_fall, cs_start, cs_end;
    assign sclk_rise = sclk_s & ~sclk_d & ~csn_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~csn_s;
    assign cs_start  = ~csn_s & csn_d;
    assign cs_end    = csn_s & ~csn_d;

    // datapath registers
    st_t              state_q, state_nx;
    logic [31:0]      rx_sh, tx_sh;
    logic [4:0]       bit_cnt;
    logic [8:0]       word_cnt;
    logic [7:0]       len_q;
    logic [PTR_W-1:0] ptr_q;
    logic             miso_q, err_q;

    logic [31:0] rx_word;
    logic        word_done;
    assign rx_word   = {rx_sh[30:0], mosi_s};
    assign word_done = sclk_rise && (bit_cnt == 5'd31);

    // command word decode
    logic [7:0]       h_op, h_len;
    logic [ADDR_W-1:0] h_addr;
    logic [PTR_W-1:0] h_ptr, h_ofs;
    logic             h_op_ok, h_range_ok, hdr_ok;

    assign h_op   = rx_word[31:24];
    assign h_addr = rx_word[23:8];
    assign h_len  = rx_word[7:0];
    assign h_ptr  = h_addr[ADDR_W-1:2];
    assign h_ofs  = h_ptr - BASE_W;
    assign h_op_ok = (h_op == OP_READ) || (h_op == OP_WRITE);
    assign h_range_ok =
        (({1'b0, h_ofs} < WORDS_P) && (({1'b0, h_ofs} + (PTR_W+1)'(h_len)) <= WORDS_P)) ||
        ((h_ptr == STAT_W) && (h_len == 8'd1));
    assign hdr_ok = h_op_ok && (h_len != 8'd0) && h_range_ok && (h_addr[1:0] == 2'b00);

    // read fetch path
    logic [PTR_W-1:0]  rd_ptr, rd_ofs, wr_ofs;
    logic              rd_in_mem, wr_in_mem;
    logic [31:0]       mem_rdata, rd_word;

    assign rd_ptr    = (state_q == ST_HDR) ? h_ptr : ptr_q + 1'b1;
    assign rd_ofs    = rd_ptr - BASE_W;
    assign rd_in_mem = {1'b0, rd_ofs} < WORDS_P;
    assign rd_word   = (rd_ptr == STAT_W) ? {31'b0, err_q} :
                       rd_in_mem          ? mem_rdata      : 32'h0;

    // write commit path
    logic wr_commit, mem_we, stat_clr, err_set;
    assign wr_ofs    = ptr_q - BASE_W;
    assign wr_in_mem = {1'b0, wr_ofs} < WORDS_P;
    assign wr_commit = (state_q == ST_WR) && word_done && (word_cnt < {1'b0, len_q});
    assign mem_we    = wr_commit && wr_in_mem;
    assign stat_clr  = wr_commit && (ptr_q == STAT_W) && rx_word[0];

    spi_word_mem #(.DEPTH(MEM_WORDS), .DW(32)) mem_i (
        .clk  (clk),
        .we   (mem_we),
        .waddr(wr_ofs[MEM_AW-1:0]),
        .wdata(rx_word),
        .raddr(rd_ofs[MEM_AW-1:0]),
        .rdata(mem_rdata)
    );

    // fault detection
    logic in_burst;
    assign in_burst = (state_q == ST_RD) || (state_q == ST_WR);
    assign err_set =
        ((state_q == ST_HDR) && word_done && !hdr_ok) ||
        (in_burst && word_done && (word_cnt >= {1'b0, len_q})) ||
        (cs_end && (state_q == ST_HDR) && (bit_cnt != 5'd0)) ||
        (cs_end && in_burst && ((bit_cnt != 5'd0) || (word_cnt != {1'b0, len_q})));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_start) state_nx = ST_HDR;
            ST_HDR: begin
                if (cs_end)         state_nx = ST_IDLE;
                else if (word_done) state_nx = !hdr_ok ? ST_DRAIN :
                                               (h_op == OP_READ) ? ST_RD : ST_WR;
            end
            ST_RD, ST_WR: begin
                if (cs_end) state_nx = ST_IDLE;
                else if (word_done && (word_cnt >= {1'b0, len_q})) state_nx = ST_DRAIN;
            end
            ST_DRAIN: if (cs_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            tx_sh    <= '0;
            bit_cnt  <= '0;
            word_cnt <= '0;
            len_q    <= '0;
            ptr_q    <= '0;
            miso_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (cs_start) begin
                rx_sh    <= '0;
                tx_sh    <= '0;
                bit_cnt  <= '0;
                word_cnt <= '0;
            end
            if (sclk_rise) begin
                rx_sh   <= rx_word;
                bit_cnt <= bit_cnt + 5'd1;
                if (word_done) begin
                    unique case (state_q)
                        ST_HDR: begin
                            len_q <= h_len;
                            ptr_q <= h_ptr;
                            tx_sh <= (hdr_ok && (h_op == OP_READ)) ? rd_word : 32'h0;
                        end
                        ST_RD, ST_WR: begin
                            word_cnt <= word_cnt + 9'd1;
                            ptr_q    <= ptr_q + 1'b1;
                            tx_sh    <= ((state_q == ST_RD) &&
                                         ((word_cnt + 9'd1) < {1'b0, len_q})) ? rd_word : 32'h0;
                        end
                        default: tx_sh <= 32'h0;
                    endcase
                end
            end
            if (sclk_fall) begin
                miso_q <= tx_sh[31];
                tx_sh  <= {tx_sh[30:0], 1'b0};
            end
            if (state_q == ST_IDLE) miso_q <= 1'b0;
            if (err_set)       err_q <= 1'b1;
            else if (stat_clr) err_q <= 1'b0;
        end
    end

    assign spi_miso = miso_q;
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk
    import spi_burst_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input st_t        state,
    input logic       mem_we,
    input logic       wr_in_mem,
    input logic [8:0] word_cnt,
    input logic [7:0] len_q,
    input logic       err_q,
    input logic       stat_clr,
    input logic       miso
);
    // R8
    write_only_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_WR));

    // R6
    write_within_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (word_cnt < {1'b0, len_q}));

    // R9
    write_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_in_mem);

    // R10
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !stat_clr) |=> err_q);

    // R3
    miso_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (miso == 1'b0));
endmodule

bind spi_burst_slave spi_burst_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .mem_we   (mem_we),
    .wr_in_mem(wr_in_mem),
    .word_cnt (word_cnt),
    .len_q    (len_q),
    .err_q    (err_q),
    .stat_clr (stat_clr),
    .miso     (spi_miso)
);

// File: tb/spi_burst_slave_tb.sv
module spi_burst_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    int   n_chk = 0;
    int   n_err = 0;
    logic [31:0] wbuf [8];
    logic [31:0] rbuf [8];

    always #5 clk = ~clk;

    spi_burst_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_sclk(sclk),
        .spi_cs_n(cs_n),
        .spi_mosi(mosi),
        .spi_miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd(input logic [7:0] op, input logic [15:0] a,
                                       input logic [7:0] n);
        return {op, a, n};
    endfunction

    task automatic shift_word(input logic [31:0] w, input int nb, output logic [31:0] r);
        r = '0;
        for (int i = 0; i < nb; i++) begin
            mosi = w[31-i];
            wait_clk(8);
            r = {r[30:0], miso};
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
        end
    endtask

    // command word, then nwords data words; the last one carries last_bits bits
    task automatic xfer(input logic [31:0] c, input int nwords, input int last_bits);
        logic [31:0] r;
        cs_n = 1'b0;
        wait_clk(8);
        shift_word(c, 32, r);
        for (int k = 0; k < nwords; k++) begin
            shift_word(wbuf[k], (k == nwords - 1) ? last_bits : 32, r);
            rbuf[k] = r;
        end
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic write1(input logic [15:0] a, input logic [31:0] d);
        wbuf[0] = d;
        xfer(cmd(8'h61, a, 8'd1), 1, 32);
    endtask

    task automatic read1(input logic [15:0] a, output logic [31:0] d);
        wbuf[0] = 32'h0;
        xfer(cmd(8'h41, a, 8'd1), 1, 32);
        d = rbuf[0];
    endtask

    task automatic err_state(output logic [31:0] s);
        read1(16'h000C, s);
    endtask

    task automatic clear_err();
        write1(16'h000C, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] s;
        check("R11 miso after reset", {31'b0, miso}, 32'h0);
        err_state(s);
        check("R11 error flag after reset", s, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] s;
        wbuf[0] = 32'hA5A5_0001; wbuf[1] = 32'h8000_0002; wbuf[2] = 32'h0123_4567;
        xfer(cmd(8'h61, 16'h8000, 8'd3), 3, 32);
        for (int k = 0; k < 3; k++) wbuf[k] = 32'h0;
        xfer(cmd(8'h41, 16'h8000, 8'd3), 3, 32);
        check("R2 R3 R1 burst word0", rbuf[0], 32'hA5A5_0001);
        check("R2 R3 burst word1", rbuf[1], 32'h8000_0002);
        check("R2 R3 burst word2", rbuf[2], 32'h0123_4567);
        read1(16'h8004, s);
        check("R2 single read of middle word", s, 32'h8000_0002);
        err_state(s);
        check("R2 no error on clean burst", s, 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] s;
        write1(16'h87FC, 32'hFEED_BEEF);
        read1(16'h87FC, s);
        check("R4 top word", s, 32'hFEED_BEEF);
        read1(16'h8000, s);
        check("R4 bottom word", s, 32'hA5A5_0001);
        err_state(s);
        check("R4 no error at boundaries", s, 32'h0);
    endtask

    task automatic t_len_zero();
        logic [31:0] s;
        xfer(cmd(8'h41, 16'h8000, 8'd0), 0, 32);
        err_state(s);
        check("R7 zero count flags error", s, 32'h1);
        write1(16'h000C, 32'h0);
        err_state(s);
        check("R10 writing 0 keeps flag", s, 32'h1);
        clear_err();
        err_state(s);
        check("R10 writing 1 clears flag", s, 32'h0);
    endtask

    task automatic t_bad_op();
        logic [31:0] s;
        write1(16'h8010, 32'h1111_1111);
        wbuf[0] = 32'h2222_2222;
        xfer(cmd(8'h55, 16'h8010, 8'd1), 1, 32);
        err_state(s);
        check("R8 unknown op flags error", s, 32'h1);
        clear_err();
        read1(16'h8010, s);
        check("R8 unknown op writes nothing", s, 32'h1111_1111);
    endtask

    task automatic t_past_end();
        logic [31:0] s;
        wbuf[0] = 32'h3333_3333; wbuf[1] = 32'h4444_4444;
        xfer(cmd(8'h61, 16'h87FC, 8'd2), 2, 32);
        err_state(s);
        check("R9 overrun flags error", s, 32'h1);
        clear_err();
        read1(16'h87FC, s);
        check("R9 overrun writes nothing", s, 32'hFEED_BEEF);
        write1(16'h8012, 32'h5555_5555);
        err_state(s);
        check("R9 unaligned flags error", s, 32'h1);
        clear_err();
        read1(16'h8010, s);
        check("R9 unaligned writes nothing", s, 32'h1111_1111);
    endtask

    task automatic t_trunc();
        logic [31:0] s;
        wbuf[0] = 32'h6666_6666; wbuf[1] = 32'h7777_7777;
        xfer(cmd(8'h61, 16'h8020, 8'd2), 2, 32);
        wbuf[0] = 32'h8888_8888; wbuf[1] = 32'h9999_9999;
        xfer(cmd(8'h61, 16'h8020, 8'd2), 2, 16);
        err_state(s);
        check("R5 partial word flags error", s, 32'h1);
        clear_err();
        read1(16'h8020, s);
        check("R5 full word before cut is stored", s, 32'h8888_8888);
        read1(16'h8024, s);
        check("R5 partial word discarded", s, 32'h7777_7777);
        xfer(cmd(8'h41, 16'h8000, 8'd1), 0, 32);
        cs_n = 1'b0; wait_clk(8); shift_word(32'h0, 8, s); wait_clk(8); cs_n = 1'b1; wait_clk(12);
        err_state(s);
        check("R5 partial command word flags error", s, 32'h1);
        clear_err();
    endtask

    task automatic t_count();
        logic [31:0] s;
        wbuf[0] = 32'h0;
        xfer(cmd(8'h41, 16'h8000, 8'd3), 1, 32);
        err_state(s);
        check("R6 too few words flags error", s, 32'h1);
        clear_err();
        wbuf[0] = 32'hAAAA_0000; wbuf[1] = 32'hBBBB_0000;
        xfer(cmd(8'h61, 16'h8030, 8'd2), 2, 32);
        wbuf[0] = 32'hCCCC_0000; wbuf[1] = 32'hDDDD_0000;
        xfer(cmd(8'h61, 16'h8030, 8'd1), 2, 32);
        err_state(s);
        check("R6 too many words flags error", s, 32'h1);
        clear_err();
        read1(16'h8030, s);
        check("R6 counted word stored", s, 32'hCCCC_0000);
        read1(16'h8034, s);
        check("R6 extra word not stored", s, 32'hBBBB_0000);
    endtask

    initial begin
        bit done = 1'b0;
        fork
            begin
                wait_clk(5);
                rst_n = 1'b1;
                wait_clk(5);
                t_reset();
                t_burst();
                t_edges();
                t_len_zero();
                t_bad_op();
                t_past_end();
                t_trunc();
                t_count();
                check("R3 miso idle at end", {31'b0, miso}, 32'h0);
                done = 1'b1;
            end
            begin
                repeat (190000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule